// File: doc/BRIEF.md
# Late-Write Synchronous SRAM with Matched Read/Write Latency

This block is a synchronous static memory whose write data arrives a fixed number of cycles after the write command. That delay equals the delay between a read command and its read data. Because the two delays match, a host can put any mix of reads and writes on consecutive clock edges and use the data lanes on every cycle, with no idle cycle when it switches direction. Each word holds four byte lanes of nine bits, so the default word is 36 bits wide. Any subset of lanes can be written.

The `flow_mode` pin is static and selects one of two timings:

- **Registered timing** (`flow_mode`=0): read data comes out of an output register one edge after the address edge. Write data is taken two edges after the command.
- **Flow-through timing** (`flow_mode`=1): read data appears straight after the address edge. Write data is taken one edge after the command.

A low-active clock enable freezes the whole pipeline. Three chip selects with mixed polarities must all be active for an access to start, and the load strobe must also be active. The read side has an output-enable input and a drive-enable output (`rdata_oe`). A pad ring uses `rdata_oe` as the tristate control of a shared data bus. Commands and data move at fixed latency with no back-pressure, so the data lanes are plain pins and not a valid/ready stream.

Top module: `lw_sram`

## Requirements
- R1: While `cke_n` is high, a rising edge changes no state. The command pipeline, the array and the read output register all hold, and `rdata`/`rdata_oe` keep their values.
- R2: An access starts on an enabled edge only when all four of these hold: `cs0_n`=0, `cs1`=1, `cs2_n`=0 and `adv_ld_n`=0. If any one of them fails, that edge starts nothing: no write lands and no read result appears.
- R3: In registered timing, a read started at edge k drives its data during the cycle after edge k+1. During the cycle after edge k it does not drive.
- R4: In flow-through timing, a read started at edge k drives its data during the cycle after edge k.
- R5: In registered timing, a write started at edge k takes `wdata` at enabled edge k+2.
- R6: In flow-through timing, a write started at edge k takes `wdata` at enabled edge k+1.
- R7: `wr_n`=1 selects a read, and the strobes are then ignored. With `wr_n`=0, each strobe `bw_n[i]`=0 writes lane i, which is bits [9i+8:9i]. All strobes low writes the whole word. All strobes high writes nothing.
- R8: In registered timing, a read issued on the edge just after a write to the same address returns that write's new lanes merged over the old contents.
- R9: `rdata_oe` is high only when `out_en` is high and a read result is due in that cycle. Whenever `rdata_oe` is low, `rdata` is zero.
- R10: Reads and writes may alternate on consecutive edges with no idle edge between them, and every result is correct.
- R11: If clock enable suppresses a write's data edge, the write takes `wdata` at the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears the pipeline valids |
| flow_mode | input | 1 | 1 = flow-through timing, 0 = registered timing (static) |
| cke_n | input | 1 | Clock enable, active low |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| adv_ld_n | input | 1 | Load-new-address strobe, active low |
| wr_n | input | 1 | 0 = write, 1 = read |
| bw_n | input | LANES | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*LANE_W | Late write data |
| out_en | input | 1 | Output enable |
| rdata | output | LANES*LANE_W | Read data, zero when not driving |
| rdata_oe | output | 1 | Drive enable for the shared data bus |

## Verification
The assertions assume the following about the inputs:
- `flow_mode` does not change while operations are in flight.
- Reset is applied before the first access.

The stimulus meets both conditions:
- Timing is switched only after several idle edges.
- Only addresses that have already been written are read, so the array never returns an unknown value.

Every input changes on the falling edge, so the rising-edge sampling that the properties describe never sees inputs change at the edge itself.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/lw_sram_cmdpipe.sv
module lw_sram_cmdpipe
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              sel,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  output op_e               s1_op,
  output logic [ADDR_W-1:0] s1_addr,
  output logic [LANES-1:0]  s1_keep,
  output op_e               s2_op,
  output logic [ADDR_W-1:0] s2_addr,
  output logic [LANES-1:0]  s2_keep
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_IDLE;
      s1_addr <= '0;
      s1_keep <= '0;
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_keep <= '0;
    end else if (run) begin
      s1_op   <= !sel ? OP_IDLE : (wr_n ? OP_READ : OP_WRITE);
      s1_addr <= addr;
      s1_keep <= ~bw_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_keep <= s1_keep;
    end
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s2_op) && $stable(s2_addr)));

  assert_nosel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !sel) |=> (s1_op == OP_IDLE));
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wkeep,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && wkeep[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end
    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flow_mode,
  input  logic                    cke_n,
  input  logic                    cs0_n,
  input  logic                    cs1,
  input  logic                    cs2_n,
  input  logic                    adv_ld_n,
  input  logic                    wr_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    out_en,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);
  localparam int DW = LANES * LANE_W;

  logic              run, sel;
  op_e               s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_keep, s2_keep;

  assign run = !cke_n;
  assign sel = !cs0_n && cs1 && !cs2_n && !adv_ld_n;

  lw_sram_cmdpipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk(clk), .rst_n(rst_n), .run(run), .sel(sel), .wr_n(wr_n),
    .addr(addr), .bw_n(bw_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_keep(s1_keep),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_keep(s2_keep)
  );

  // Commit stage depends on timing mode: one or two edges after the command.
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [LANES-1:0]  wkeep;
  logic [DW-1:0]     arr_q;

  assign we    = run && (flow_mode ? (s1_op == OP_WRITE) : (s2_op == OP_WRITE));
  assign waddr = flow_mode ? s1_addr : s2_addr;
  assign wkeep = flow_mode ? s1_keep : s2_keep;

  lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(we), .waddr(waddr), .wkeep(wkeep), .wdata(wdata),
    .raddr(s1_addr), .rdata(arr_q)
  );

  // Registered timing: a write committing on the same edge as the output
  // register load must be seen by that load.
  logic          fwd_hit;
  logic [DW-1:0] merged;

  assign fwd_hit = (s2_op == OP_WRITE) && (s2_addr == s1_addr);

  for (genvar g = 0; g < LANES; g++) begin : g_fwd
    assign merged[g*LANE_W +: LANE_W] = (fwd_hit && s2_keep[g]) ?
      wdata[g*LANE_W +: LANE_W] : arr_q[g*LANE_W +: LANE_W];
  end

  logic          oq_vld;
  logic [DW-1:0] oq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oq_vld <= 1'b0;
      oq     <= '0;
    end else if (run) begin
      oq_vld <= (s1_op == OP_READ);
      oq     <= merged;
    end
  end

  logic          rd_vld;
  logic [DW-1:0] rd_val;

  assign rd_vld   = flow_mode ? (s1_op == OP_READ) : oq_vld;
  assign rd_val   = flow_mode ? arr_q : oq;
  assign rdata_oe = out_en && rd_vld;
  assign rdata    = rdata_oe ? rd_val : '0;

  assert_plread_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_mode && run && s1_op == OP_READ) |=> oq_vld);

  assert_ftread_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_mode && run && sel && wr_n) |=> (!out_en || rdata_oe));

  assert_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> (!rdata_oe && rdata == '0));
endmodule

// File: tb/lw_sram_test.sv
`timescale 1ns/1ps
module lw_sram_test;
  localparam int AW = 6;
  localparam int DW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flow_mode = 1'b0;
  logic cke_n = 1'b0, cs0_n = 1'b1, cs1 = 1'b0, cs2_n = 1'b1, adv_ld_n = 1'b1, wr_n = 1'b1;
  logic [3:0] bw_n = 4'hF;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic out_en = 1'b1;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lw_sram uut (
    .clk(clk), .rst_n(rst_n), .flow_mode(flow_mode), .cke_n(cke_n),
    .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n), .adv_ld_n(adv_ld_n),
    .wr_n(wr_n), .bw_n(bw_n), .addr(addr), .wdata(wdata),
    .out_en(out_en), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  localparam logic [DW-1:0] D1 = 36'h1_2345_6789;
  localparam logic [DW-1:0] JUNK = 36'hB_ADBA_DBAD;

  function automatic logic [DW-1:0] mrg(logic [DW-1:0] old, logic [DW-1:0] nw, logic [3:0] keep);
    logic [DW-1:0] r = old;
    for (int i = 0; i < 4; i++) if (keep[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // op: 0 idle, 1 read, 2 write; brk: 1..4 breaks one select condition
  task automatic step(bit run, int op, logic [AW-1:0] a, logic [3:0] bw,
                      logic [DW-1:0] wd, int brk = 0);
    cke_n    = !run;
    cs0_n    = (op == 0) || (brk == 1);
    cs1      = !(brk == 2);
    cs2_n    = (brk == 3);
    adv_ld_n = (brk == 4);
    wr_n     = (op != 2);
    addr     = a;
    bw_n     = bw;
    wdata    = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(logic [DW-1:0] wd = '0);
    step(1, 0, '0, 4'hF, wd);
  endtask

  task automatic wr_pl(logic [AW-1:0] a, logic [3:0] bw, logic [DW-1:0] d);
    step(1, 2, a, bw, JUNK);
    idle(JUNK);
    idle(d);
  endtask

  task automatic rd_pl(logic [AW-1:0] a, logic [DW-1:0] exp, string req);
    step(1, 1, a, 4'h0, JUNK);
    idle();
    chk(req, {35'd0, rdata_oe}, 36'd1);
    chk(req, rdata, exp);
  endtask

  task automatic t_reset;
    chk("R9 reset oe", {35'd0, rdata_oe}, 36'd0);
    chk("R9 reset data", rdata, '0);
  endtask

  task automatic t_pl_basic;
    wr_pl(6'd1, 4'h0, D1);
    step(1, 1, 6'd1, 4'h0, JUNK);
    chk("R3 not early", {35'd0, rdata_oe}, 36'd0);
    idle();
    chk("R3 oe", {35'd0, rdata_oe}, 36'd1);
    chk("R5 data", rdata, D1);
  endtask

  task automatic t_bytes;
    logic [DW-1:0] a = 36'hA_AAAA_AAAA, b = 36'h5_5555_5555;
    wr_pl(6'd2, 4'h0, a);
    wr_pl(6'd2, 4'b1010, b);
    rd_pl(6'd2, mrg(a, b, 4'b0101), "R7 partial");
    wr_pl(6'd2, 4'hF, 36'h0_0000_0000);
    rd_pl(6'd2, mrg(a, b, 4'b0101), "R7 noop");
    step(1, 1, 6'd2, 4'h0, JUNK);   // read ignores strobes
    idle();
    chk("R7 read strobes ignored", rdata, mrg(a, b, 4'b0101));
  endtask

  task automatic t_fwd;
    logic [DW-1:0] e = 36'h3_1415_9265, f = 36'hC_AFEC_AFEC;
    wr_pl(6'd3, 4'h0, e);
    step(1, 2, 6'd3, 4'b1100, JUNK);
    step(1, 1, 6'd3, 4'h0, JUNK);
    idle(f);
    chk("R8 forward", rdata, mrg(e, f, 4'b0011));
    rd_pl(6'd3, mrg(e, f, 4'b0011), "R8 array after forward");
  endtask

  task automatic t_b2b;
    logic [DW-1:0] p5 = 36'h5_0505_0505, p6 = 36'h6_0606_0606;
    step(1, 2, 6'd5, 4'h0, JUNK);
    step(1, 1, 6'd1, 4'h0, JUNK);
    step(1, 2, 6'd6, 4'h0, p5);
    chk("R10 read between writes", rdata, D1);
    step(1, 1, 6'd5, 4'h0, JUNK);
    idle(p6);
    chk("R10 read after write", rdata, p5);
    rd_pl(6'd6, p6, "R10 second write");
  endtask

  task automatic t_ft;
    logic [DW-1:0] p8 = 36'h8_8888_0000;
    flow_mode = 1'b1;
    idle(); idle();
    step(1, 2, 6'd8, 4'h0, JUNK);
    step(1, 1, 6'd8, 4'h0, p8);
    chk("R6 ft write edge", rdata, p8);
    chk("R4 ft oe", {35'd0, rdata_oe}, 36'd1);
    step(1, 1, 6'd1, 4'h0, JUNK);
    chk("R4 ft read", rdata, D1);
    idle();
    chk("R4 ft idle no drive", {35'd0, rdata_oe}, 36'd0);
    flow_mode = 1'b0;
    idle(); idle();
  endtask

  task automatic t_cke;
    logic [DW-1:0] p11 = 36'h1_1111_1111;
    step(1, 2, 6'd11, 4'h0, JUNK);
    idle(JUNK);
    step(0, 0, '0, 4'hF, JUNK);
    idle(p11);
    rd_pl(6'd11, p11, "R11 delayed data edge");
    step(1, 1, 6'd1, 4'h0, JUNK);
    idle();
    step(0, 0, '0, 4'hF, JUNK);
    chk("R1 hold data", rdata, D1);
    step(0, 1, 6'd5, 4'h0, JUNK);
    chk("R1 hold oe", {35'd0, rdata_oe}, 36'd1);
    chk("R1 hold data 2", rdata, D1);
    idle();
    chk("R1 resumes", {35'd0, rdata_oe}, 36'd0);
  endtask

  task automatic t_desel;
    for (int b = 1; b <= 4; b++) begin
      step(1, 2, 6'd1, 4'h0, JUNK, b);
      idle(JUNK);
      idle(JUNK);
    end
    rd_pl(6'd1, D1, "R2 no write when deselected");
    step(1, 1, 6'd1, 4'h0, JUNK, 2);
    idle();
    chk("R2 no read when deselected", {35'd0, rdata_oe}, 36'd0);
  endtask

  task automatic t_oe;
    out_en = 1'b0;
    step(1, 1, 6'd1, 4'h0, JUNK);
    idle();
    chk("R9 oe off", {35'd0, rdata_oe}, 36'd0);
    chk("R9 data zero", rdata, '0);
    out_en = 1'b1;
    #0.5;
    chk("R9 oe on", rdata, D1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_pl_basic();
    t_bytes();
    t_fwd();
    t_b2b();
    t_ft();
    t_cke();
    t_desel();
    t_oe();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule